// File: doc/BRIEF.md
# Label Acceptance Filter

This block sits between a serial word receiver and the receive buffer that follows it. Each 32-bit word that arrives carries an 8-bit label in its lowest byte. The filter keeps a bitmap with one bit for each of the 256 possible labels. When filtering is switched on, a word goes on to the buffer only if the bit for its label is set. A word whose bit is clear is dropped without any sign at the output. When filtering is switched off, every word goes through.

A host port writes the bitmap one byte at a time and can read any byte back. The accept or drop decision is taken in the cycle the input strobe is present. The result is a registered one-cycle output strobe that carries the unchanged word in the next cycle.

Top module: `label_filter`

## Requirements
- R1: While reset is asserted and after it is released, `outValid` is 0 and every bitmap byte reads back as 8'h00.
- R2: With `filterEn`=1, a word whose label bit is 0 produces no `outValid` pulse.
- R3: With `filterEn`=1, a word whose label bit is 1 produces `outValid`=1 for exactly one cycle, in the cycle after `inValid` was sampled.
- R4: With `filterEn`=0, every word presented with `inValid` passes, whatever the bitmap holds.
- R5: The label is `inWord[7:0]`. Bits [31:8] have no influence on the decision.
- R6: A write with `tblWrEn`=1 stores `tblWrData` into byte `tblAddr`. Bit k of byte a is the entry for label 8*a+k.
- R7: `tblRdData` shows the byte selected by `tblAddr` combinationally, without a clock edge.
- R8: When a bitmap write and an input word meet in the same cycle, the decision uses the bitmap contents from before that write. The write affects words from the next cycle on.
- R9: `outWord` equals the accepted `inWord` bit for bit while `outValid` is 1, and `outValid` is 0 in any cycle after one with `inValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filterEn | input | 1 | 1 = apply the label bitmap, 0 = pass every word |
| inValid | input | 1 | Strobe for a received word |
| inWord | input | 32 | Received word, label in bits [7:0] |
| tblWrEn | input | 1 | Write strobe for the bitmap byte |
| tblAddr | input | 5 | Byte address for writes and reads |
| tblWrData | input | 8 | Byte to store |
| tblRdData | output | 8 | Byte at `tblAddr` |
| outValid | output | 1 | One-cycle strobe for an accepted word |
| outWord | output | 32 | Accepted word |

## Verification
A host update of the bitmap and an arriving word whose label falls in the byte being written can land in the same clock cycle. The bench provokes this in both directions. It sets a clear bit while a word with that label arrives, and it clears a set bit while a word with that label arrives. In both cases it drives the write strobe and the input strobe on the same falling edge. It expects the first word to be decided by the old bitmap value. It then sends the same label again and expects the new value to decide the outcome.

// File: rtl/label_filter_pkg.sv
package label_filter_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic tblWrite;  // store the host byte into the bitmap
    logic capture;   // register the incoming word and raise outValid
  } lfStrobe_t;

endpackage

// File: rtl/label_filter_ctrl.sv
module label_filter_ctrl
  import label_filter_pkg::*;
(
  input  logic      inValid,
  input  logic      filterEn,
  input  logic      tblWrEn,
  input  logic      admitBit,
  output lfStrobe_t strobes
);

  logic passAll;

  // Bypass when filtering is off; otherwise the bitmap bit rules (R2, R4)
  assign passAll = ~filterEn;

  always_comb begin
    strobes          = '0;
    strobes.tblWrite = tblWrEn;
    strobes.capture  = inValid & (passAll | admitBit);
  end

endmodule

// File: rtl/label_filter_dp.sv
module label_filter_dp
  import label_filter_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LABEL_W = 8,
  parameter int SLICE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  lfStrobe_t             strobes,
  input  logic [WORD_W-1:0]     inWord,
  input  logic [$clog2((1<<LABEL_W)/SLICE_W)-1:0] tblAddr,
  input  logic [SLICE_W-1:0]    tblWrData,
  output logic                  admitBit,
  output logic [SLICE_W-1:0]    tblRdData,
  output logic                  outValid,
  output logic [WORD_W-1:0]     outWord
);

  localparam int ENTRIES = 1 << LABEL_W;
  localparam int SLICES  = ENTRIES / SLICE_W;
  localparam int ADDR_W  = $clog2(SLICES);
  localparam int BIT_W   = $clog2(SLICE_W);

  logic [SLICE_W-1:0] tblMem [SLICES];
  logic [LABEL_W-1:0] label;
  logic [ADDR_W-1:0]  labelSlice;
  logic [BIT_W-1:0]   labelBit;

  // Label taken from the low bits of the word (R5)
  assign label      = inWord[LABEL_W-1:0];
  assign labelSlice = label[LABEL_W-1:BIT_W];
  assign labelBit   = label[BIT_W-1:0];

  // Old contents are seen here during a same-cycle write (R8)
  assign admitBit  = tblMem[labelSlice][labelBit];
  assign tblRdData = tblMem[tblAddr];  // R7

  // Bitmap storage, cleared by reset (R1, R6)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SLICES; s++) tblMem[s] <= '0;
    end else if (strobes.tblWrite) begin
      tblMem[tblAddr] <= tblWrData;
    end
  end

  // Output register (R3, R9)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outWord  <= '0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) outWord <= inWord;
    end
  end

  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.tblWrite |=> tblMem[$past(tblAddr)] == $past(tblWrData))
    else $error("R6 bitmap write not stored");

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!outValid && tblMem[0] == '0))
    else $error("R1 reset state wrong");

endmodule

// File: rtl/label_filter.sv
module label_filter
  import label_filter_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LABEL_W = 8,
  parameter int SLICE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                filterEn,
  input  logic                inValid,
  input  logic [WORD_W-1:0]   inWord,
  input  logic                tblWrEn,
  input  logic [$clog2((1<<LABEL_W)/SLICE_W)-1:0] tblAddr,
  input  logic [SLICE_W-1:0]  tblWrData,
  output logic [SLICE_W-1:0]  tblRdData,
  output logic                outValid,
  output logic [WORD_W-1:0]   outWord
);

  lfStrobe_t strobes;
  logic      admitBit;

  label_filter_ctrl u_ctrl (
    .inValid  (inValid),
    .filterEn (filterEn),
    .tblWrEn  (tblWrEn),
    .admitBit (admitBit),
    .strobes  (strobes)
  );

  label_filter_dp #(
    .WORD_W  (WORD_W),
    .LABEL_W (LABEL_W),
    .SLICE_W (SLICE_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .inWord    (inWord),
    .tblAddr   (tblAddr),
    .tblWrData (tblWrData),
    .admitBit  (admitBit),
    .tblRdData (tblRdData),
    .outValid  (outValid),
    .outWord   (outWord)
  );

  a_r4_bypass_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !filterEn) |=> outValid)
    else $error("R4 bypassed word lost");

  a_r2_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && filterEn && !admitBit) |=> !outValid)
    else $error("R2 rejected word leaked");

  a_r3_accept_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && filterEn && admitBit) |=> outValid)
    else $error("R3 admitted word lost");

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid)
    else $error("R9 strobe without input");

  a_r9_word_intact: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && outValid == 1'b0 && !filterEn |=> outWord == $past(inWord))
    else $error("R9 word altered");

endmodule

// File: tb/label_filter_test.sv
module label_filter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        filterEn;
  logic        inValid;
  logic [31:0] inWord;
  logic        tblWrEn;
  logic [4:0]  tblAddr;
  logic [7:0]  tblWrData;
  logic [7:0]  tblRdData;
  logic        outValid;
  logic [31:0] outWord;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  label_filter uut (
    .clk(clk), .rst_n(rst_n), .filterEn(filterEn), .inValid(inValid),
    .inWord(inWord), .tblWrEn(tblWrEn), .tblAddr(tblAddr),
    .tblWrData(tblWrData), .tblRdData(tblRdData),
    .outValid(outValid), .outWord(outWord)
  );

  // Vector: {filterEn, expectPass, word}
  localparam logic [33:0] VEC [10] = '{
    {1'b1, 1'b1, 32'hDEAD_BE00},  // R3 label 0 set
    {1'b1, 1'b0, 32'h1234_5601},  // R2 label 1 clear
    {1'b1, 1'b1, 32'hFFFF_FF02},  // R3 label 2 set
    {1'b1, 1'b1, 32'h0000_00FF},  // R3 label 255 set
    {1'b1, 1'b1, 32'hABCD_EF84},  // R3 label 0x84 set
    {1'b1, 1'b0, 32'hABCD_EF85},  // R2 label 0x85 clear
    {1'b0, 1'b1, 32'h1111_1101},  // R4 bypass, label clear
    {1'b0, 1'b1, 32'h5A5A_5A33},  // R4 bypass
    {1'b1, 1'b0, 32'h0000_0103},  // R5 upper bits look like label 1
    {1'b1, 1'b1, 32'h8765_4300}   // R5 upper bits differ, label 0
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    tblWrEn = 1'b1; tblAddr = a; tblWrData = d;
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic readByte(input logic [4:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    tblAddr = a;
    #1;
    check(tblRdData == exp, req, {24'h0, tblRdData}, {24'h0, exp});
  endtask

  task automatic sendWord(input bit en, input logic [31:0] w, input bit expPass,
                          input string req);
    @(negedge clk);
    filterEn = en; inValid = 1'b1; inWord = w;
    @(posedge clk);
    #1;
    inValid = 1'b0;
    check(outValid == expPass, req, {31'h0, outValid}, {31'h0, expPass});
    if (expPass) check(outWord == w, req, outWord, w);
  endtask

  initial begin
    int cycles = 0;
    while (!finished && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; filterEn = 1'b0; inValid = 1'b0; inWord = '0;
    tblWrEn = 1'b0; tblAddr = '0; tblWrData = '0;
    repeat (3) @(posedge clk);
    #1;
    check(outValid == 1'b0, "R1 outValid in reset", {31'h0, outValid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: whole bitmap reads zero after reset
    for (int a = 0; a < 32; a++) readByte(a[4:0], 8'h00, "R1 bitmap clear");

    // R6: labels 0,2 ; 0x84 ; 0xFF
    writeByte(5'd0, 8'h05);
    writeByte(5'd16, 8'h10);
    writeByte(5'd31, 8'h80);

    // R7 readback
    readByte(5'd0, 8'h05, "R7 readback byte 0");
    readByte(5'd16, 8'h10, "R7 readback byte 16");
    readByte(5'd31, 8'h80, "R7 readback byte 31");
    readByte(5'd5, 8'h00, "R7 untouched byte");

    // Vector walk
    for (int i = 0; i < 10; i++)
      sendWord(VEC[i][33], VEC[i][31:0], VEC[i][32], "R2/R3/R4/R5 vector");

    // R9: idle cycle after an accepted word gives no strobe
    @(posedge clk);
    #1;
    check(outValid == 1'b0, "R9 single-cycle strobe", {31'h0, outValid}, 32'h0);

    // R8: set label 0x40 (byte 8 bit 0) in the same cycle as its word
    @(negedge clk);
    tblWrEn = 1'b1; tblAddr = 5'd8; tblWrData = 8'h01;
    filterEn = 1'b1; inValid = 1'b1; inWord = 32'hCAFE_0040;
    @(posedge clk);
    #1;
    tblWrEn = 1'b0; inValid = 1'b0;
    check(outValid == 1'b0, "R8 old clear bit decides", {31'h0, outValid}, 32'h0);
    sendWord(1'b1, 32'hCAFE_0040, 1'b1, "R8 new set bit decides");

    // R8: clear label 0 in the same cycle as its word
    @(negedge clk);
    tblWrEn = 1'b1; tblAddr = 5'd0; tblWrData = 8'h04;
    filterEn = 1'b1; inValid = 1'b1; inWord = 32'hBEEF_0000;
    @(posedge clk);
    #1;
    tblWrEn = 1'b0; inValid = 1'b0;
    check(outValid == 1'b1, "R8 old set bit decides", {31'h0, outValid}, 32'h1);
    check(outWord == 32'hBEEF_0000, "R9 word intact", outWord, 32'hBEEF_0000);
    sendWord(1'b1, 32'hBEEF_0000, 1'b0, "R8 new clear bit decides");
    sendWord(1'b1, 32'h0000_0002, 1'b1, "R6 neighbour bit kept");

    // R6: top bit of byte 31 -> label 255 ; clear it
    writeByte(5'd31, 8'h00);
    sendWord(1'b1, 32'h0000_00FF, 1'b0, "R6 label 255 cleared");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule